// File: doc/BRIEF.md
# Trace Cache Fill and Lookup

This block gathers a dynamic instruction stream into a fill buffer and turns it into traces. A trace may span taken branches, so instructions that sit far apart in memory end up side by side in one entry. Each completed trace is written into a direct-mapped store. The entry is keyed by the address of its first instruction and by the outcomes of the branches it contains.

A fetch stage presents a fetch address and its predicted branch outcomes on the lookup port. When both the key address and the outcomes of the stored branches agree, the block hands back the whole trace, up to sixteen instructions, with its length. A mode input chooses which stream feeds the fill buffer: the speculative fetch stream or the retiring commit stream.

Top module: `trace_cache_fill`

## Requirements
- R1: After reset, `trHit` is 0, `trCnt` is 0 and every lookup misses.
- R2: With `srcSel`=0 only the fetch stream (`fet*`) fills traces, and with `srcSel`=1 only the commit stream (`cmt*`) does. Activity on the unselected stream never creates an entry.
- R3: A trace closes on its 16th instruction, and that instruction is included.
- R4: A trace closes on the instruction that carries its 3rd branch, and that instruction is included.
- R5: A trace also closes on an instruction flagged as a system call or as mispredicted, and that instruction is included.
- R6: Taken branches and address discontinuities do not close a trace. The instructions are returned in arrival order, regardless of their addresses.
- R7: A lookup hits only if the entry at index `lkAddr[7:2]` is valid, its full start address equals `lkAddr`, and `lkPred[i]` equals the stored outcome for each stored branch i (bit i is the i-th branch in the trace, 1 = taken). Bits of `lkPred` beyond the stored branch count are ignored.
- R8: On a hit, `trCnt` gives the trace length (1 to 16), and slot i of `trInstr` (bits `32*i+31:32*i`) holds the i-th instruction of the trace. On a miss, `trCnt` is 0.
- R9: Writing a trace replaces whatever entry is at its index, so the earlier start address then misses.
- R10: A one-cycle pulse on `invalidate` makes every stored trace miss. A trace that closes in that same cycle is not stored.
- R11: Lookup results are registered. They appear in the cycle after `lkVld` is sampled, and `trHit` is 0 in the cycle after a cycle with `lkVld` low.
- R12: The instruction after a closed trace begins a new trace, keyed by its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 1 | Fill source: 0 = fetch stream, 1 = commit stream |
| fetVld | input | 1 | Fetch stream instruction valid |
| fetAddr | input | 32 | Fetch stream instruction address |
| fetInstr | input | 32 | Fetch stream instruction word |
| fetIsBr | input | 1 | Fetch stream instruction is a conditional branch |
| fetTaken | input | 1 | Fetch stream branch outcome (1 = taken) |
| fetIsSys | input | 1 | Fetch stream instruction is a system call |
| fetMisp | input | 1 | Fetch stream instruction was mispredicted |
| cmtVld | input | 1 | Commit stream instruction valid |
| cmtAddr | input | 32 | Commit stream instruction address |
| cmtInstr | input | 32 | Commit stream instruction word |
| cmtIsBr | input | 1 | Commit stream instruction is a conditional branch |
| cmtTaken | input | 1 | Commit stream branch outcome (1 = taken) |
| cmtIsSys | input | 1 | Commit stream instruction is a system call |
| cmtMisp | input | 1 | Commit stream instruction was mispredicted |
| invalidate | input | 1 | Clear every stored trace |
| lkVld | input | 1 | Lookup request valid |
| lkAddr | input | 32 | Lookup fetch address |
| lkPred | input | 3 | Predicted outcomes, bit i for the i-th branch |
| trHit | output | 1 | Registered lookup hit |
| trCnt | output | 5 | Number of valid instructions in `trInstr` |
| trInstr | output | 512 | Trace instructions, slot i in bits 32*i+31:32*i |

## Verification
An instruction is sampled at a rising edge. If it closes a trace, the entry is written at that same edge, so a lookup issued in the next cycle already sees it. A lookup sampled at edge t shows its result on `trHit`, `trCnt` and `trInstr` right after edge t. The bench drives every input on the falling edge and holds each request for exactly one rising edge. It reads the outputs one nanosecond after that edge, which places each check in the one cycle where the result is due. To see the invalidate and source-select effects at the ports, the bench runs lookups of the addresses that could have been touched, before any new fill can reach them.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_ADDR_W    = 32;
  localparam int TC_INSTR_W   = 32;
  localparam int TC_MAX_INSTR = 16;
  localparam int TC_MAX_BR    = 3;
  localparam int TC_ENTRIES   = 64;
  localparam int TC_ALIGN     = 2;

  localparam int TC_SLOT_W = $clog2(TC_MAX_INSTR);
  localparam int TC_BRI_W  = $clog2(TC_MAX_BR);

  // strobes from control to datapath
  typedef struct packed {
    logic                 take;
    logic                 first;
    logic                 commit;
    logic                 clearAll;
    logic                 isBr;
    logic [TC_SLOT_W-1:0] slot;
    logic [TC_BRI_W-1:0]  brSlot;
  } tcStrobeT;
endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int MAX_INSTR = TC_MAX_INSTR,
  parameter int MAX_BR    = TC_MAX_BR
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inVld,
  input  logic     inBr,
  input  logic     inSys,
  input  logic     inMisp,
  input  logic     invalidate,
  output tcStrobeT stb
);
  localparam int SLOT_W = TC_SLOT_W;
  localparam int BRI_W  = TC_BRI_W;

  logic [SLOT_W-1:0] slotCnt;
  logic [BRI_W-1:0]  brSeen;
  logic lastSlot, lastBr, closeNow;

  always_comb begin
    lastSlot = (slotCnt == SLOT_W'(MAX_INSTR - 1));
    lastBr   = inBr && (brSeen == BRI_W'(MAX_BR - 1));
    closeNow = inVld && (lastSlot || lastBr || inSys || inMisp);

    stb.take     = inVld;
    stb.first    = inVld && (slotCnt == '0);
    stb.commit   = closeNow && !invalidate;
    stb.clearAll = invalidate;
    stb.isBr     = inVld && inBr;
    stb.slot     = slotCnt;
    stb.brSlot   = brSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      brSeen  <= '0;
    end else if (closeNow) begin
      slotCnt <= '0;
      brSeen  <= '0;
    end else if (inVld) begin
      slotCnt <= slotCnt + SLOT_W'(1);
      if (inBr) brSeen <= brSeen + BRI_W'(1);
    end
  end
endmodule

// File: rtl/tc_dpath.sv
module tc_dpath
  import tc_pkg::*;
#(
  parameter int ADDR_W    = TC_ADDR_W,
  parameter int INSTR_W   = TC_INSTR_W,
  parameter int MAX_INSTR = TC_MAX_INSTR,
  parameter int MAX_BR    = TC_MAX_BR,
  parameter int ENTRIES   = TC_ENTRIES,
  parameter int ALIGN     = TC_ALIGN
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tcStrobeT                      stb,
  input  logic [ADDR_W-1:0]             inAddr,
  input  logic [INSTR_W-1:0]            inInstr,
  input  logic                          inTaken,
  input  logic                          lkVld,
  input  logic [ADDR_W-1:0]             lkAddr,
  input  logic [MAX_BR-1:0]             lkPred,
  output logic                          trHit,
  output logic [$clog2(MAX_INSTR+1)-1:0] trCnt,
  output logic [MAX_INSTR*INSTR_W-1:0]  trInstr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(MAX_INSTR + 1);
  localparam int BRC_W = $clog2(MAX_BR + 1);

  // fill buffer
  logic [INSTR_W-1:0] fillBuf [MAX_INSTR];
  logic [ADDR_W-1:0]  startAddrR;
  logic [MAX_BR-1:0]  outBits;

  // trace store
  logic [INSTR_W-1:0] instrMem [ENTRIES][MAX_INSTR];
  logic [ADDR_W-1:0]  tagMem   [ENTRIES];
  logic [CNT_W-1:0]   cntMem   [ENTRIES];
  logic [BRC_W-1:0]   brCntMem [ENTRIES];
  logic [MAX_BR-1:0]  outMem   [ENTRIES];
  logic [ENTRIES-1:0] validBits;

  logic [ADDR_W-1:0]  wrAddr;
  logic [IDX_W-1:0]   wrIdx;
  logic [MAX_BR-1:0]  nextOut;
  logic [CNT_W-1:0]   wrCnt;
  logic [BRC_W-1:0]   wrBrCnt;

  always_comb begin
    wrAddr  = stb.first ? inAddr : startAddrR;
    wrIdx   = wrAddr[ALIGN +: IDX_W];
    nextOut = stb.first ? '0 : outBits;
    if (stb.isBr) nextOut[stb.brSlot] = inTaken;
    wrCnt   = CNT_W'(stb.slot) + CNT_W'(1);
    wrBrCnt = BRC_W'(stb.brSlot) + BRC_W'(stb.isBr);
  end

  // fill buffer capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddrR <= '0;
      outBits    <= '0;
    end else if (stb.take) begin
      if (stb.first) startAddrR <= inAddr;
      outBits <= nextOut;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.take) fillBuf[stb.slot] <= inInstr;
  end

  // trace write, merging the closing instruction into its slot
  always_ff @(posedge clk) begin
    if (stb.commit) begin
      for (int s = 0; s < MAX_INSTR; s++) begin
        if (s == int'(stb.slot)) instrMem[wrIdx][s] <= inInstr;
        else                     instrMem[wrIdx][s] <= fillBuf[s];
      end
      tagMem[wrIdx]   <= wrAddr;
      cntMem[wrIdx]   <= wrCnt;
      brCntMem[wrIdx] <= wrBrCnt;
      outMem[wrIdx]   <= nextOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             validBits <= '0;
    else if (stb.clearAll) validBits <= '0;
    else if (stb.commit)   validBits[wrIdx] <= 1'b1;
  end

  // lookup
  logic [IDX_W-1:0]  rdIdx;
  logic [MAX_BR-1:0] useMask;
  logic              outMatch, hitNext;

  always_comb begin
    rdIdx = lkAddr[ALIGN +: IDX_W];
    for (int b = 0; b < MAX_BR; b++)
      useMask[b] = (BRC_W'(b) < brCntMem[rdIdx]);
    outMatch = ((lkPred ^ outMem[rdIdx]) & useMask) == '0;
    hitNext  = lkVld && validBits[rdIdx] && (tagMem[rdIdx] == lkAddr) && outMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trHit   <= 1'b0;
      trCnt   <= '0;
      trInstr <= '0;
    end else begin
      trHit <= hitNext;
      trCnt <= hitNext ? cntMem[rdIdx] : '0;
      for (int s = 0; s < MAX_INSTR; s++)
        trInstr[s*INSTR_W +: INSTR_W] <= hitNext ? instrMem[rdIdx][s] : '0;
    end
  end
endmodule

// File: rtl/trace_cache_fill.sv
module trace_cache_fill
  import tc_pkg::*;
#(
  parameter int ADDR_W    = TC_ADDR_W,
  parameter int INSTR_W   = TC_INSTR_W,
  parameter int MAX_INSTR = TC_MAX_INSTR,
  parameter int MAX_BR    = TC_MAX_BR,
  parameter int ENTRIES   = TC_ENTRIES,
  parameter int ALIGN     = TC_ALIGN
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           srcSel,
  input  logic                           fetVld,
  input  logic [ADDR_W-1:0]              fetAddr,
  input  logic [INSTR_W-1:0]             fetInstr,
  input  logic                           fetIsBr,
  input  logic                           fetTaken,
  input  logic                           fetIsSys,
  input  logic                           fetMisp,
  input  logic                           cmtVld,
  input  logic [ADDR_W-1:0]              cmtAddr,
  input  logic [INSTR_W-1:0]             cmtInstr,
  input  logic                           cmtIsBr,
  input  logic                           cmtTaken,
  input  logic                           cmtIsSys,
  input  logic                           cmtMisp,
  input  logic                           invalidate,
  input  logic                           lkVld,
  input  logic [ADDR_W-1:0]              lkAddr,
  input  logic [MAX_BR-1:0]              lkPred,
  output logic                           trHit,
  output logic [$clog2(MAX_INSTR+1)-1:0] trCnt,
  output logic [MAX_INSTR*INSTR_W-1:0]   trInstr
);
  logic               selVld, selBr, selTaken, selSys, selMisp;
  logic [ADDR_W-1:0]  selAddr;
  logic [INSTR_W-1:0] selInstr;
  tcStrobeT           strobes;
  logic               wrStb;

  always_comb begin
    selVld   = srcSel ? cmtVld   : fetVld;
    selAddr  = srcSel ? cmtAddr  : fetAddr;
    selInstr = srcSel ? cmtInstr : fetInstr;
    selBr    = srcSel ? cmtIsBr  : fetIsBr;
    selTaken = srcSel ? cmtTaken : fetTaken;
    selSys   = srcSel ? cmtIsSys : fetIsSys;
    selMisp  = srcSel ? cmtMisp  : fetMisp;
  end

  assign wrStb = strobes.commit;

  tc_ctrl #(.MAX_INSTR(MAX_INSTR), .MAX_BR(MAX_BR)) i_ctrl (
    .clk(clk), .rstN(rstN), .inVld(selVld), .inBr(selBr), .inSys(selSys),
    .inMisp(selMisp), .invalidate(invalidate), .stb(strobes)
  );

  tc_dpath #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .MAX_INSTR(MAX_INSTR),
    .MAX_BR(MAX_BR), .ENTRIES(ENTRIES), .ALIGN(ALIGN)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(strobes), .inAddr(selAddr),
    .inInstr(selInstr), .inTaken(selTaken), .lkVld(lkVld), .lkAddr(lkAddr),
    .lkPred(lkPred), .trHit(trHit), .trCnt(trCnt), .trInstr(trInstr)
  );
endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
  parameter int CNT_W     = 5,
  parameter int MAX_INSTR = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             srcSel,
  input logic             fetVld,
  input logic             fetIsSys,
  input logic             fetMisp,
  input logic             cmtVld,
  input logic             cmtIsSys,
  input logic             cmtMisp,
  input logic             invalidate,
  input logic             lkVld,
  input logic             trHit,
  input logic [CNT_W-1:0] trCnt,
  input logic             wrStb
);
  logic chkVld, chkEnd;
  assign chkVld = srcSel ? cmtVld : fetVld;
  assign chkEnd = srcSel ? (cmtIsSys || cmtMisp) : (fetIsSys || fetMisp);

  AST_HIT_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    trHit |-> (trCnt >= CNT_W'(1)) && (trCnt <= CNT_W'(MAX_INSTR))); // R8
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !trHit |-> trCnt == '0); // R8
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !lkVld |=> !trHit); // R11
  AST_END_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (chkVld && chkEnd && !invalidate) |-> wrStb); // R5
  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !chkVld |-> !wrStb); // R2
  AST_INV_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |-> !wrStb); // R10
endmodule

bind trace_cache_fill tc_chk #(.CNT_W($clog2(MAX_INSTR+1)), .MAX_INSTR(MAX_INSTR)) i_tc_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .fetVld(fetVld), .fetIsSys(fetIsSys),
  .fetMisp(fetMisp), .cmtVld(cmtVld), .cmtIsSys(cmtIsSys), .cmtMisp(cmtMisp),
  .invalidate(invalidate), .lkVld(lkVld), .trHit(trHit), .trCnt(trCnt), .wrStb(wrStb)
);

// File: tb/test_trace_cache_fill.sv
module test_trace_cache_fill;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, srcSel, invalidate, lkVld;
  logic fetVld, fetIsBr, fetTaken, fetIsSys, fetMisp;
  logic cmtVld, cmtIsBr, cmtTaken, cmtIsSys, cmtMisp;
  logic [31:0] fetAddr, fetInstr, cmtAddr, cmtInstr, lkAddr;
  logic [2:0] lkPred;
  logic trHit;
  logic [4:0] trCnt;
  logic [511:0] trInstr;

  int checks = 0;
  int errors = 0;
  logic [31:0] recA [16];
  int recN = 0;

  trace_cache_fill i_trace_cache_fill (
    .clk(clk), .rstN(rstN), .srcSel(srcSel),
    .fetVld(fetVld), .fetAddr(fetAddr), .fetInstr(fetInstr), .fetIsBr(fetIsBr),
    .fetTaken(fetTaken), .fetIsSys(fetIsSys), .fetMisp(fetMisp),
    .cmtVld(cmtVld), .cmtAddr(cmtAddr), .cmtInstr(cmtInstr), .cmtIsBr(cmtIsBr),
    .cmtTaken(cmtTaken), .cmtIsSys(cmtIsSys), .cmtMisp(cmtMisp),
    .invalidate(invalidate), .lkVld(lkVld), .lkAddr(lkAddr), .lkPred(lkPred),
    .trHit(trHit), .trCnt(trCnt), .trInstr(trInstr)
  );

  function automatic logic [31:0] wordOf(input logic [31:0] a);
    return (a * 32'd5) ^ 32'h3C00_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one instruction on the selected stream; the other stream carries a
  // system call at 0x600 that must never be stored
  task automatic pushI(input logic [31:0] a, input logic br, input logic tk,
                       input logic sys, input logic misp);
    @(negedge clk);
    if (srcSel) begin
      cmtVld = 1; cmtAddr = a; cmtInstr = wordOf(a); cmtIsBr = br; cmtTaken = tk;
      cmtIsSys = sys; cmtMisp = misp;
      fetVld = 1; fetAddr = 32'h600; fetInstr = wordOf(32'h600); fetIsBr = 0;
      fetTaken = 0; fetIsSys = 1; fetMisp = 0;
    end else begin
      fetVld = 1; fetAddr = a; fetInstr = wordOf(a); fetIsBr = br; fetTaken = tk;
      fetIsSys = sys; fetMisp = misp;
      cmtVld = 1; cmtAddr = 32'h600; cmtInstr = wordOf(32'h600); cmtIsBr = 0;
      cmtTaken = 0; cmtIsSys = 1; cmtMisp = 0;
    end
    @(posedge clk);
    #1;
    fetVld = 0; cmtVld = 0;
    if (recN < 16) begin
      recA[recN] = a;
      recN++;
    end
  endtask

  task automatic look(input logic [31:0] a, input logic [2:0] pred, input logic expHit,
                      input int n, input string req);
    @(negedge clk);
    lkVld = 1; lkAddr = a; lkPred = pred;
    @(posedge clk);
    #1;
    lkVld = 0;
    chk(req, {31'd0, trHit}, {31'd0, expHit});
    chk(req, {27'd0, trCnt}, expHit ? n : 0);
    if (expHit)
      for (int i = 0; i < n; i++)
        chk("R8 slot", trInstr[i*32 +: 32], wordOf(recA[i]));
  endtask

  task automatic tReset;
    chk("R1 hit", {31'd0, trHit}, 0);
    chk("R1 cnt", {27'd0, trCnt}, 0);
    look(32'h100, 3'b000, 0, 0, "R1 lookup");
  endtask

  task automatic tFull;
    srcSel = 0;
    recN = 0;
    for (int i = 0; i < 16; i++) pushI(32'h100 + 4*i, 0, 0, 0, 0);
    look(32'h100, 3'b000, 1, 16, "R3 sixteen");
    look(32'h600, 3'b000, 0, 0, "R2 commit ignored");
    recN = 0;
    pushI(32'h140, 0, 0, 1, 0);
    look(32'h140, 3'b000, 1, 1, "R12 next start R5 syscall");
  endtask

  task automatic tBranch;
    srcSel = 1;
    recN = 0;
    pushI(32'h300, 0, 0, 0, 0);
    pushI(32'h304, 1, 1, 0, 0);
    pushI(32'h800, 0, 0, 0, 0);
    pushI(32'h804, 1, 0, 0, 0);
    pushI(32'h808, 1, 1, 0, 0);
    look(32'h300, 3'b101, 1, 5, "R4 third branch R6 taken");
    look(32'h300, 3'b100, 0, 0, "R7 outcome mismatch");
    look(32'h100, 3'b000, 0, 0, "R9 replaced");
    look(32'h600, 3'b000, 0, 0, "R2 fetch ignored");
  endtask

  task automatic tMask;
    recN = 0;
    pushI(32'h410, 0, 0, 0, 0);
    pushI(32'h414, 1, 1, 0, 0);
    pushI(32'h418, 0, 0, 0, 1);
    look(32'h410, 3'b111, 1, 3, "R7 unused bits R5 misp");
    look(32'h410, 3'b001, 1, 3, "R7 unused bits");
    look(32'h410, 3'b110, 0, 0, "R7 used bit");
    look(32'h510, 3'b001, 0, 0, "R7 tag");
    look(32'h410, 3'b001, 1, 3, "R11 hit");
    @(posedge clk);
    #1;
    chk("R11 idle", {31'd0, trHit}, 0);
  endtask

  task automatic tInval;
    @(negedge clk);
    invalidate = 1;
    @(posedge clk);
    #1;
    invalidate = 0;
    look(32'h410, 3'b001, 0, 0, "R10 a");
    look(32'h140, 3'b000, 0, 0, "R10 b");
    look(32'h300, 3'b101, 0, 0, "R10 c");
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rstN = 0; srcSel = 0; invalidate = 0; lkVld = 0; lkAddr = 0; lkPred = 0;
    fetVld = 0; fetAddr = 0; fetInstr = 0; fetIsBr = 0; fetTaken = 0; fetIsSys = 0; fetMisp = 0;
    cmtVld = 0; cmtAddr = 0; cmtInstr = 0; cmtIsBr = 0; cmtTaken = 0; cmtIsSys = 0; cmtMisp = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    #1;
    tReset();
    tFull();
    tBranch();
    tMask();
    tInval();
    summary();
  end
endmodule